// File: doc/BRIEF.md
# Serial Converter Readout Sequencer

This block is the digital control side of a sampled converter with a four-wire serial port: an active-low chip select, a serial clock, serial data in and serial data out. It steps through a fixed cycle of converting, sleeping and shifting out a result. The converter core is not part of the block. A start pulse goes out to the core, and the finished result comes back over a valid/ready stream. While a word is shifted out, the block also collects a short mode word from the serial input. It applies that mode to the core when the next conversion starts.

All four serial pins are brought into the system clock domain through a synchronizer of `SYNC_STAGES` flops. The block acts on edges of the synchronized serial clock. The serial clock must therefore stay in each phase for longer than `SYNC_STAGES + 2` system clocks.

The result stream accepts a transfer when `res_valid` and `res_ready` are both high on a clock edge. `res_ready` is high only while a conversion is in progress and drops in the cycle after the transfer. It stays low until the next conversion is started. A producer holds `res_valid` and the result fields steady until the transfer takes place, so back-pressure lasts for the whole sleep and readout period.

Top module: `sdadc_seq`

## Requirements
- R1: After reset, `conv_start` is high for exactly one cycle, which is the first cycle after reset is released. At that point `res_ready` is 1, `sdo_oe` is 0, and all four mode outputs are 0 (the default mode, which rejects both mains frequencies).
- R2: A result is accepted only on a clock edge where `res_valid` and `res_ready` are both high. `res_ready` is low in the next cycle and stays low until `conv_start` pulses again.
- R3: The readout word is 32 bits, sent most significant bit first. Bit 31 is the ready flag (0 means a valid result). Bit 30 is a filler that is always 0. Bit 29 is `res_sign`. Bits 28 to 5 are `res_code`, MSB first. Bits 4 to 0 are `res_sub`. After the 32nd bit the output reads 0.
- R4: Bit 31 is on `sdo` within `SYNC_STAGES + 1` clocks of the select falling, before any serial clock edge. Each later bit appears within `SYNC_STAGES + 1` clocks of a serial clock falling edge. `sdi` is taken on serial clock rising edges.
- R5: `sdo_oe` is 0 whenever the synchronized select is high, and 1 whenever it is low.
- R6: If the select is low while a conversion is in progress, `sdo` reads 1. The select has no effect on the conversion.
- R7: If the select rises before any serial clock rising edge, the block goes back to sleep. It does not pulse `conv_start`, and the stored word is kept for a later full read.
- R8: If the select rises after at least one serial clock rising edge, the readout stops. `conv_start` then pulses once and `res_ready` returns to 1.
- R9: The first five `sdi` bits of a readout are the mode word, in this order: enable, temperature select, rejection A, rejection B, speed. When a conversion starts, the four mode outputs take the last four of those bits. This happens only if all five bits arrived and the enable bit was 1. Otherwise the mode outputs keep their values.
- R10: The mode outputs change only in the cycle in which `conv_start` is high.
- R11: While the block sleeps, the stored word does not change, however long the sleep lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in (mode word) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (0 means high impedance) |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_sign | input | 1 | Sign of the result |
| res_code | input | 24 | Result magnitude code |
| res_sub | input | 5 | Sub-LSB bits |
| cfg_temp_sel | output | 1 | Mode: measure internal temperature |
| cfg_rej_a | output | 1 | Mode: rejection select A |
| cfg_rej_b | output | 1 | Mode: rejection select B |
| cfg_speed | output | 1 | Mode: doubled output rate |

## Verification
A wrong sequencer state shows on `sdo` within `SYNC_STAGES + 1` clocks of the select falling. A block stuck in conversion reads 1 where the ready flag should be 0. A block that wrongly left sleep shows `res_ready` high, or an extra `conv_start` pulse, when the select rises. A misaligned or corrupted shift register shows up in the first mismatching bit of a readout. A mode register that was loaded at the wrong moment shows on the mode outputs in the cycle after the conversion starts.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sdadc_pin_sync.sv
module sdadc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_n_o,
  output logic sdi_o,
  output logic sck_rise_o,
  output logic sck_fall_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE_LVL = 3'b001;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic            sck_prev;

  assign pin_raw = {sdi_i, sck_i, cs_n_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{IDLE_LVL[g]}};
      else        pipe <= {pipe[STAGES-2:0], pin_raw[g]};
    end
    assign pin_s[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= pin_s[1];
  end

  assign cs_n_o     = pin_s[0];
  assign sdi_o      = pin_s[2];
  assign sck_rise_o = pin_s[1] & ~sck_prev;
  assign sck_fall_o = ~pin_s[1] & sck_prev;
endmodule

// File: rtl/sdadc_word_shifter.sv
module sdadc_word_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= load_word;
    else if (shift) shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  assign msb_o  = shreg[WORD_W-1];
  assign word_o = shreg;
endmodule

// File: rtl/sdadc_cfg_capture.sv
module sdadc_cfg_capture #(
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             sdi,
  input  logic             apply,
  output logic [CFG_W-2:0] mode_o
);
  localparam int CNT_W = $clog2(CFG_W + 1);

  logic [CFG_W-1:0] cap;
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign full = (cnt == CNT_W'(CFG_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
      cnt <= '0;
    end else if (clear) begin
      cap <= '0;
      cnt <= '0;
    end else if (sample && !full) begin
      cap <= {cap[CFG_W-2:0], sdi};
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mode_o <= '0;
    else if (apply && full && cap[CFG_W-1]) mode_o <= cap[CFG_W-2:0];
  end
endmodule

// File: rtl/sdadc_seq.sv
module sdadc_seq
  import sdadc_pkg::*;
#(
  parameter int RES_W       = 24,
  parameter int SUB_W       = 5,
  parameter int CFG_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             conv_start,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic             res_sign,
  input  logic [RES_W-1:0] res_code,
  input  logic [SUB_W-1:0] res_sub,
  output logic             cfg_temp_sel,
  output logic             cfg_rej_a,
  output logic             cfg_rej_b,
  output logic             cfg_speed
);
  localparam int WORD_W = 3 + RES_W + SUB_W;

  seq_state_e state, state_nx;

  logic              cs_s, sdi_s, sck_rise, sck_fall;
  logic              seen_rise;
  logic              boot;
  logic              conv_start_q;
  logic              in_out, enter_conv, load;
  logic              shifter_msb;
  logic [WORD_W-1:0] shreg_word;
  logic [WORD_W-1:0] fresh_word;
  logic [CFG_W-2:0]  cfg_mode;

  sdadc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .cs_n_o(cs_s), .sdi_o(sdi_s),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall)
  );

  assign in_out     = (state == ST_OUT);
  assign enter_conv = in_out && cs_s && seen_rise;
  assign load       = (state == ST_CONV) && res_valid;
  assign fresh_word = {1'b0, 1'b0, res_sign, res_code, res_sub};

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_CONV:  if (res_valid) state_nx = ST_SLEEP;
      ST_SLEEP: if (!cs_s)     state_nx = ST_OUT;
      ST_OUT:   if (cs_s)      state_nx = seen_rise ? ST_CONV : ST_SLEEP;
      default:                 state_nx = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_CONV;
      seen_rise    <= 1'b0;
      boot         <= 1'b1;
      conv_start_q <= 1'b0;
    end else begin
      state        <= state_nx;
      boot         <= 1'b0;
      conv_start_q <= boot | enter_conv;
      if (!in_out)                    seen_rise <= 1'b0;
      else if (sck_rise && !cs_s)     seen_rise <= 1'b1;
    end
  end

  sdadc_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_word(fresh_word),
    .shift(in_out && !cs_s && seen_rise && sck_fall),
    .msb_o(shifter_msb), .word_o(shreg_word)
  );

  sdadc_cfg_capture #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .clear(!in_out),
    .sample(in_out && !cs_s && sck_rise),
    .sdi(sdi_s),
    .apply(enter_conv),
    .mode_o(cfg_mode)
  );

  assign sdo          = (state == ST_CONV) ? 1'b1 : shifter_msb;
  assign sdo_oe       = !cs_s;
  assign conv_start   = conv_start_q;
  assign res_ready    = (state == ST_CONV);
  assign cfg_temp_sel = cfg_mode[CFG_W-2];
  assign cfg_rej_a    = cfg_mode[CFG_W-3];
  assign cfg_rej_b    = cfg_mode[CFG_W-4];
  assign cfg_speed    = cfg_mode[CFG_W-5];
endmodule

// File: rtl/sdadc_seq_chk.sv
module sdadc_seq_chk
  import sdadc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_e        state,
  input logic [WORD_W-1:0] shreg,
  input logic              conv_start,
  input logic              res_valid,
  input logic              res_ready,
  input logic [MODE_W-1:0] cfg_mode
);
  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_ready);

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R8
  ready_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_ready) |-> conv_start);

  // R10
  mode_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_mode) |-> conv_start);

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> $stable(shreg));

  // R7
  early_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && $past(state) == ST_OUT) |-> (!conv_start && $stable(shreg)));
endmodule

bind sdadc_seq sdadc_seq_chk #(.WORD_W(WORD_W), .MODE_W(CFG_W-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .shreg(shreg_word),
  .conv_start(conv_start), .res_valid(res_valid), .res_ready(res_ready),
  .cfg_mode(cfg_mode)
);

// File: tb/sdadc_seq_bench.sv
`timescale 1ns/1ps
module sdadc_seq_bench;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_oe, conv_start, res_ready;
  logic        res_valid = 1'b0, res_sign = 1'b0;
  logic [23:0] res_code = '0;
  logic [4:0]  res_sub = '0;
  logic        cfg_temp_sel, cfg_rej_a, cfg_rej_b, cfg_speed;

  int checks = 0, fails = 0, starts = 0, cyc = 0;
  logic [3:0] exp_mode = 4'b0000;

  always #2.5 clk = ~clk;

  sdadc_seq u_sdadc_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start),
    .res_valid(res_valid), .res_ready(res_ready), .res_sign(res_sign),
    .res_code(res_code), .res_sub(res_sub),
    .cfg_temp_sel(cfg_temp_sel), .cfg_rej_a(cfg_rej_a),
    .cfg_rej_b(cfg_rej_b), .cfg_speed(cfg_speed)
  );

  // sign, code, sub, mode word (enable first)
  localparam logic [34:0] VEC [4] = '{
    {1'b1, 24'hABCDEF, 5'h15, 5'b11010},
    {1'b0, 24'h000001, 5'h00, 5'b00101},
    {1'b1, 24'hFFFFFF, 5'h1F, 5'b10001},
    {1'b0, 24'h800000, 5'h0A, 5'b10000}
  };

  always @(negedge clk) begin
    if (rst_n && conv_start) starts++;
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mode_now();
    return {cfg_temp_sel, cfg_rej_a, cfg_rej_b, cfg_speed};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give_result(input logic s, input logic [23:0] c, input logic [4:0] u);
    @(negedge clk);
    res_valid = 1'b1; res_sign = s; res_code = c; res_sub = u;
    forever begin
      @(posedge clk);
      if (res_ready) break;
    end
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic read_frame(input logic [4:0] cfg, input int nrise, output logic [31:0] got);
    got = '0;
    cs_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      wait_n(H);
      got[31-i] = sdo;
      if (i >= nrise) break;
      sdi = (i < 5) ? cfg[4-i] : 1'b0;
      wait_n(1);
      sck = 1'b1;
      wait_n(H);
      sck = 1'b0;
    end
    sdi = 1'b0;
  endtask

  initial begin
    logic [31:0] got, exp_w;
    int s0;
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(conv_start == 1'b1, "R1 conv_start after reset", 32'(conv_start), 32'd1);
    check(res_ready == 1'b1 && sdo_oe == 1'b0 && mode_now() == 4'b0,
          "R1 ready/oe/mode after reset", {res_ready, sdo_oe, mode_now()}, 32'h20);
    @(negedge clk);
    check(conv_start == 1'b0, "R1 single start pulse", 32'(conv_start), 32'd0);

    // R6 select low during conversion
    cs_n = 1'b0; wait_n(H);
    check(sdo_oe == 1'b1 && sdo == 1'b1, "R6 busy flag reads 1", {sdo_oe, sdo}, 32'h3);
    cs_n = 1'b1; wait_n(H);
    check(sdo_oe == 1'b0, "R5 oe low with select high", 32'(sdo_oe), 32'd0);
    check(res_ready == 1'b1, "R6 conversion unaffected", 32'(res_ready), 32'd1);

    for (int v = 0; v < 4; v++) begin
      give_result(VEC[v][34], VEC[v][33:10], VEC[v][9:5]);
      wait_n(1);
      check(res_ready == 1'b0, "R2 ready drops after accept", 32'(res_ready), 32'd0);
      s0 = starts;
      read_frame(VEC[v][4:0], 32, got);
      exp_w = {2'b00, VEC[v][34], VEC[v][33:10], VEC[v][9:5]};
      check(got == exp_w, "R3 R4 word readout", got, exp_w);
      wait_n(H);
      check(sdo == 1'b0, "R3 zero after last bit", 32'(sdo), 32'd0);
      cs_n = 1'b1; wait_n(H);
      if (VEC[v][4]) exp_mode = VEC[v][3:0];
      check(starts == s0 + 1, "R8 start after full read", 32'(starts), 32'(s0 + 1));
      check(mode_now() == exp_mode, "R9 mode word applied", 32'(mode_now()), 32'(exp_mode));
      check(res_ready == 1'b1, "R2 ready back on start", 32'(res_ready), 32'd1);
    end

    // R7 early abort keeps result, R11 long sleep
    give_result(1'b0, 24'h5A5A5A, 5'h11);
    s0 = starts;
    cs_n = 1'b0; wait_n(H);
    check(sdo == 1'b0 && sdo_oe == 1'b1, "R4 ready flag before any clock", {sdo_oe, sdo}, 32'h2);
    cs_n = 1'b1; wait_n(H);
    check(res_ready == 1'b0 && starts == s0, "R7 back to sleep, no start",
          {res_ready, 8'(starts - s0)}, 32'h0);
    wait_n(300);
    read_frame(5'b01111, 32, got);
    exp_w = {3'b000, 24'h5A5A5A, 5'h11};
    check(got == exp_w, "R11 R7 word held after abort", got, exp_w);
    cs_n = 1'b1; wait_n(H);
    check(mode_now() == exp_mode, "R9 enable 0 keeps mode", 32'(mode_now()), 32'(exp_mode));

    // R8 abort after three rises, R9 short mode word ignored
    give_result(1'b1, 24'h123456, 5'h03);
    s0 = starts;
    read_frame(5'b11111, 3, got);
    check(got[31:29] == 3'b001, "R8 partial prefix", 32'(got[31:29]), 32'h1);
    cs_n = 1'b1; wait_n(H);
    check(starts == s0 + 1 && res_ready == 1'b1, "R8 abort restarts conversion",
          {res_ready, 8'(starts - s0)}, 32'h101);
    check(mode_now() == exp_mode, "R9 short mode word ignored", 32'(mode_now()), 32'(exp_mode));

    give_result(1'b0, 24'h0F0F0F, 5'h1E);
    read_frame(5'b00000, 32, got);
    exp_w = {3'b000, 24'h0F0F0F, 5'h1E};
    check(got == exp_w, "R3 fresh word after abort", got, exp_w);
    cs_n = 1'b1; wait_n(H);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule